// File: doc/BRIEF.md
# Three-Wire Crosstalk Coupling Classifier

This block looks at one transfer on a 4-bit on-chip bus and works out what kind of capacitive coupling stress it causes. It takes the word now on the bus and the word that was on the bus in the previous transfer. For each wire it records whether the wire rose, fell or stayed still. It then looks at each window of three neighbouring wires and places that window's transitions into one of five coupling classes. Class 0 is the mildest and class 4 is the worst.

The block has no clock and no storage. The surrounding logic registers the previous word. That logic also uses the class flags to pick a bus encoding, for example inverting the word when a severe class is seen. The 8-bit transition vector is also brought out so other logic can use it.

In each three-wire window, the middle wire is the victim and the two outer wires are its aggressors. A window raises at most one class. A pattern that fits none of the classes raises nothing. The clearest case is a still centre wire with only a neighbour switching.

Top module: `xtalk_class_detect`

## Requirements
- R1: `transVec[3:0]` holds the rise bits. Bit i is 1 exactly when bit i of `prevWord` is 0 and bit i of `curWord` is 1.
- R2: `transVec[7:4]` holds the fall bits. Bit 4+i is 1 exactly when bit i of `prevWord` is 1 and bit i of `curWord` is 0. A wire never shows a rise and a fall at once.
- R3: `classFlag[0]` is set when, in some window, all three wires make the same move: all rise, all fall, or all stay still. When `prevWord` equals `curWord`, `classFlag` is exactly 5'b00001.
- R4: `classFlag[1]` is set when, in some window, the centre wire switches, no neighbour moves opposite to it, and at least one neighbour is still.
- R5: `classFlag[2]` is set when, in some window, the centre switches, one neighbour moves opposite to it and the other neighbour moves the same way as the centre.
- R6: `classFlag[3]` is set when, in some window, the centre switches, one neighbour moves opposite to it and the other neighbour is still.
- R7: `classFlag[4]` is set when, in some window, both neighbours move opposite to the centre, as in rise/fall/rise or fall/rise/fall.
- R8: The windows are wires {0,1,2} with centre wire 1, and wires {1,2,3} with centre wire 2. Each flag is the OR of that class over both windows.
- R9: A window raises at most one class. A window whose centre is still while a neighbour switches raises no class at all.
- R10: The outputs are a purely combinational function of the two input words, with no cycle of latency.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| prevWord | input | 4 | Word carried by the bus in the previous transfer |
| curWord | input | 4 | Word about to be carried in this transfer |
| classFlag | output | 5 | Bit k is high when coupling class k occurs in any window |
| transVec | output | 8 | Rise bits in [3:0], fall bits in [7:4] |

## Verification
Directed word pairs are chosen so that each one isolates a single class in a known window:
- A pair with a lone centre switch shows class 1 in one window while the other window raises nothing.
- An alternating pattern shows class 4.
- The 0111-to-1000 step shows class 0 in one window and class 2 in the other, which proves the OR across windows.

Pairs where only an edge wire moves check that a still centre raises no flag. All 256 combinations of previous and present word are then compared against a model. That model is written in terms of signed per-wire moves, so any window mix-up, direction swap or class overlap shows up.

// File: rtl/xtalk_pkg.sv
package xtalk_pkg;
  localparam int BUS_W     = 4;
  localparam int WIN_W     = 3;
  localparam int NUM_CLASS = 5;
  localparam int NUM_WIN   = BUS_W - WIN_W + 1;

  typedef enum int {
    CLS_UNIFORM = 0,
    CLS_CENTRE  = 1,
    CLS_MIXED   = 2,
    CLS_SPLIT   = 3,
    CLS_ALTERN  = 4
  } couplingClassE;

  // strobes from one window's classifier to the flag merge
  typedef struct packed {
    logic altern;
    logic split;
    logic mixed;
    logic centre;
    logic uniform;
  } winHitT;
endpackage

// File: rtl/xtalk_edge_detect.sv
module xtalk_edge_detect #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] prevWord,
  input  logic [WIDTH-1:0] curWord,
  output logic [WIDTH-1:0] riseVec,
  output logic [WIDTH-1:0] fallVec
);
  always_comb begin
    riseVec = ~prevWord & curWord;
    fallVec = prevWord & ~curWord;
  end

  always_comb begin
    // R2
    r2_no_dual_edge_chk: assert ((riseVec & fallVec) == '0)
      else $error("wire shows rise and fall together");
    // R1
    r1_edges_cover_change_chk: assert ((riseVec | fallVec) == (prevWord ^ curWord))
      else $error("edge vectors disagree with changed bits");
  end
endmodule

// File: rtl/xtalk_window_classify.sv
module xtalk_window_classify
  import xtalk_pkg::*;
(
  input  logic [2:0] winRise,
  input  logic [2:0] winFall,
  output winHitT     hit
);
  logic quietA, quietC, quietB, centreMoves;
  logic sameAC, sameBC, oppAC, oppBC;

  always_comb begin
    quietA      = ~winRise[0] & ~winFall[0];
    quietC      = ~winRise[1] & ~winFall[1];
    quietB      = ~winRise[2] & ~winFall[2];
    centreMoves = ~quietC;
    sameAC = (winRise[0] & winRise[1]) | (winFall[0] & winFall[1]);
    sameBC = (winRise[2] & winRise[1]) | (winFall[2] & winFall[1]);
    oppAC  = (winRise[0] & winFall[1]) | (winFall[0] & winRise[1]);
    oppBC  = (winRise[2] & winFall[1]) | (winFall[2] & winRise[1]);

    hit.uniform = (sameAC & sameBC) | (quietA & quietC & quietB);
    hit.centre  = centreMoves & ~oppAC & ~oppBC & (quietA | quietB);
    hit.mixed   = centreMoves & ((oppAC & sameBC) | (oppBC & sameAC));
    hit.split   = centreMoves & ((oppAC & quietB) | (oppBC & quietA));
    hit.altern  = oppAC & oppBC;
  end

  always_comb begin
    // R9
    r9_single_class_chk: assert ($onehot0(hit))
      else $error("window raised more than one class");
    // R9
    r9_still_centre_chk: assert (!(quietC && !(quietA && quietB)) || hit == '0)
      else $error("still centre raised a class");
  end
endmodule

// File: rtl/xtalk_flag_merge.sv
module xtalk_flag_merge
  import xtalk_pkg::*;
#(
  parameter int NWIN = 2
) (
  input  winHitT [NWIN-1:0]      winHits,
  output logic   [NUM_CLASS-1:0] classFlag
);
  always_comb begin
    classFlag = '0;
    for (int w = 0; w < NWIN; w++) begin
      classFlag[CLS_UNIFORM] |= winHits[w].uniform;
      classFlag[CLS_CENTRE]  |= winHits[w].centre;
      classFlag[CLS_MIXED]   |= winHits[w].mixed;
      classFlag[CLS_SPLIT]   |= winHits[w].split;
      classFlag[CLS_ALTERN]  |= winHits[w].altern;
    end
  end

  always_comb begin
    // R8
    r8_flags_bounded_chk: assert ($countones(classFlag) <= NWIN)
      else $error("more classes than windows");
  end
endmodule

// File: rtl/xtalk_class_detect.sv
module xtalk_class_detect
  import xtalk_pkg::*;
(
  input  logic [BUS_W-1:0]     prevWord,
  input  logic [BUS_W-1:0]     curWord,
  output logic [NUM_CLASS-1:0] classFlag,
  output logic [2*BUS_W-1:0]   transVec
);
  logic   [BUS_W-1:0]   riseVec, fallVec;
  winHitT [NUM_WIN-1:0] winHits;

  xtalk_edge_detect #(.WIDTH(BUS_W)) u_edges (
    .prevWord(prevWord), .curWord(curWord),
    .riseVec(riseVec), .fallVec(fallVec)
  );

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    xtalk_window_classify u_cls (
      .winRise(riseVec[w +: WIN_W]),
      .winFall(fallVec[w +: WIN_W]),
      .hit(winHits[w])
    );
  end

  xtalk_flag_merge #(.NWIN(NUM_WIN)) u_merge (
    .winHits(winHits), .classFlag(classFlag)
  );

  assign transVec = {fallVec, riseVec};

  always_comb begin
    // R3
    r3_static_bus_chk: assert (prevWord != curWord || classFlag == 5'b00001)
      else $error("static bus did not give uniform class only");
    // R10
    r10_any_flag_chk: assert (prevWord == curWord || transVec != '0)
      else $error("changed word produced no transitions");
  end
endmodule

// File: tb/xtalk_class_detect_bench.sv
module xtalk_class_detect_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic [3:0] prevWord = '0, curWord = '0;
  logic [4:0] classFlag;
  logic [7:0] transVec;
  int total = 0, bad = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  xtalk_class_detect u_xtalk_class_detect (
    .prevWord(prevWord), .curWord(curWord),
    .classFlag(classFlag), .transVec(transVec)
  );

  function automatic int moveOf(input logic [3:0] p, input logic [3:0] c, input int i);
    if (p[i] == c[i]) return 0;
    return c[i] ? 1 : -1;
  endfunction

  function automatic logic [4:0] refFlags(input logic [3:0] p, input logic [3:0] c);
    logic [4:0] f = '0;
    for (int w = 0; w < 2; w++) begin
      int a = moveOf(p, c, w);
      int m = moveOf(p, c, w + 1);
      int b = moveOf(p, c, w + 2);
      if (a == m && m == b) f[0] = 1;
      if (m != 0 && a != -m && b != -m && (a == 0 || b == 0)) f[1] = 1;
      if (m != 0 && ((a == -m && b == m) || (b == -m && a == m))) f[2] = 1;
      if (m != 0 && ((a == -m && b == 0) || (b == -m && a == 0))) f[3] = 1;
      if (m != 0 && a == -m && b == -m) f[4] = 1;
    end
    return f;
  endfunction

  function automatic logic [7:0] refTrans(input logic [3:0] p, input logic [3:0] c);
    logic [7:0] t = '0;
    for (int i = 0; i < 4; i++) begin
      if (moveOf(p, c, i) == 1)  t[i] = 1;
      if (moveOf(p, c, i) == -1) t[4 + i] = 1;
    end
    return t;
  endfunction

  task automatic apply(input logic [3:0] p, input logic [3:0] c);
    @(negedge clk);
    prevWord = p;
    curWord  = c;
    #1;
  endtask

  task automatic checkFlags(input string req, input logic [4:0] exp);
    total++;
    if (classFlag !== exp) begin
      bad++;
      $display("FAIL %s prev=%b cur=%b flags=%b expected=%b", req, prevWord, curWord, classFlag, exp);
    end
  endtask

  task automatic checkTrans(input string req, input logic [7:0] exp);
    total++;
    if (transVec !== exp) begin
      bad++;
      $display("FAIL %s prev=%b cur=%b trans=%b expected=%b", req, prevWord, curWord, transVec, exp);
    end
  endtask

  task automatic testIdle();
    apply(4'b0000, 4'b0000);
    checkFlags("R3", 5'b00001);
    checkTrans("R1", 8'h00);
    apply(4'b1011, 4'b1011);
    checkFlags("R3", 5'b00001);
  endtask

  task automatic testEdges();
    apply(4'b0101, 4'b0110);
    checkTrans("R1", 8'b0001_0010);
    apply(4'b1100, 4'b0011);
    checkTrans("R2", 8'b1100_0011);
  endtask

  task automatic testClasses();
    apply(4'b0000, 4'b0010);
    checkFlags("R4", 5'b00010);
    apply(4'b0000, 4'b0011);
    checkFlags("R4", 5'b00010);
    apply(4'b0111, 4'b1000);
    checkFlags("R5", 5'b00101);
    apply(4'b0010, 4'b0001);
    checkFlags("R6", 5'b01000);
    apply(4'b0101, 4'b1010);
    checkFlags("R7", 5'b10000);
  endtask

  task automatic testWindows();
    apply(4'b0000, 4'b1000);
    checkFlags("R9", 5'b00001);
    apply(4'b0000, 4'b0101);
    checkFlags("R8", 5'b00010);
    apply(4'b0000, 4'b1001);
    checkFlags("R9", 5'b00000);
  endtask

  task automatic testSweep();
    for (int p = 0; p < 16; p++) begin
      for (int c = 0; c < 16; c++) begin
        apply(p[3:0], c[3:0]);
        // R10: result available in the same cycle the words are applied
        checkFlags("R10", refFlags(p[3:0], c[3:0]));
        checkTrans("R2", refTrans(p[3:0], c[3:0]));
      end
    end
  endtask

  initial begin
    testIdle();
    testEdges();
    testClasses();
    testWindows();
    testSweep();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog R10 actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule